// File: doc/BRIEF.md
# Constrained key candidate generator

This block feeds a brute-force key search. The search covers only the keys that satisfy a linear system over GF(2). The free key bits are walked by a binary counter. Each constrained bit is then derived from them. A constrained bit is the parity of a fixed subset of the free bits, inverted by one bit of a right-hand-side vector. The subsets are elaboration-time parameters. The right-hand side is captured at the start of every task. Loading a different vector, with some equations flipped, moves the search to a neighbouring subspace without rebuilding the logic.

Candidates leave through a valid/ready handshake, so several keystream units can share one generator. A pause input suppresses `cand_valid` and freezes the offered key while every consumer is busy. The constrained bits are computed ahead of a register from the counter's next value. The path from the counter to the key output is therefore one register deep. Once the last free-bit pattern has been accepted, the block raises `done` and issues nothing more until the next task starts.

Top module: `key_cand_gen`

## Requirements
- R1: While `rst_n` is low and after it is released, `cand_valid` is 0, `done` is 0 and `cand_key` is all zeros.
- R2: One cycle after a cycle with `task_start` high, `cand_valid` is high (unless `pause` is high) and the free part of `cand_key` is zero.
- R3: `cand_key[FREE_W-1:0]` holds the free bits. Bit `FREE_W+i` holds constrained bit i, which equals the XOR of the free bits selected by `DEP_MASKS[i*FREE_W +: FREE_W]`, XORed with bit i of the captured right-hand side.
- R4: A cycle with `cand_valid` and `cand_ready` both high and no `task_start` advances the free part by one in the next cycle.
- R5: While `cand_valid` is high and `cand_ready` is low, `cand_key` stays unchanged.
- R6: While `pause` is high, `cand_valid` is low in that same cycle and no candidate is consumed. The offered key is held.
- R7: After the all-ones free pattern is accepted, `done` goes high and `cand_valid` goes low in the next cycle. Both stay that way until the next `task_start`.
- R8: `task_rhs` is sampled only in a cycle with `task_start` high. Changes at any other time have no effect on `cand_key`.
- R9: `task_start` takes precedence over an acceptance in the same cycle. It restarts the enumeration at zero with the new right-hand side and clears `done`.
- R10: Before the first `task_start` after reset, no candidate is offered, whatever `cand_ready` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| task_start | input | 1 | Begin a task: clear the counter and capture `task_rhs` |
| task_rhs | input | DEP_W | Right-hand side of the constraint system for the new task |
| pause | input | 1 | Withhold candidates and freeze the offered key |
| cand_ready | input | 1 | Consumer accepts the offered candidate |
| cand_valid | output | 1 | A candidate is offered |
| cand_key | output | FREE_W+DEP_W | Candidate key: constrained bits above free bits |
| done | output | 1 | Subspace exhausted for the current task |

## Verification
The key, `cand_valid` and `done` all come from registers. Each is due one clock after the edge that sees `task_start` or an accepted handshake. The only exception is `cand_valid`, which follows `pause` in the same cycle. The bench changes inputs on the falling edge. It checks registered results at the next falling edge, after the capturing rising edge. It checks the pause response one time step after driving `pause`. Expected keys come from a bench-side parity model that uses the mask constants written in R3.

// File: rtl/kcg_pkg.sv
package kcg_pkg;
  localparam int unsigned KCG_MAX_W = 64;

  function automatic logic masked_parity(input logic [KCG_MAX_W-1:0] bits,
                                         input logic [KCG_MAX_W-1:0] sel);
    return ^(bits & sel);
  endfunction
endpackage

// File: rtl/kcg_free_counter.sv
module kcg_free_counter #(
  parameter int unsigned FREE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_zero,
  input  logic              step,
  output logic [FREE_W-1:0] free_q,
  output logic [FREE_W-1:0] free_d,
  output logic              free_en,
  output logic              at_last
);
  localparam logic [FREE_W-1:0] ONE = FREE_W'(1);

  always_comb begin
    at_last = &free_q;
    free_en = load_zero | (step & ~at_last);
    free_d  = load_zero ? '0 : (free_q + ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       free_q <= '0;
    else if (free_en) free_q <= free_d;
  end

  assert_restart_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_zero |=> (free_q == '0));

  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load_zero && !at_last) |=> (free_q == $past(free_q) + ONE));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load_zero) |=> $stable(free_q));
endmodule

// File: rtl/kcg_dep_stage.sv
module kcg_dep_stage
  import kcg_pkg::*;
#(
  parameter int unsigned             FREE_W    = 4,
  parameter int unsigned             DEP_W     = 3,
  parameter logic [DEP_W*FREE_W-1:0] DEP_MASKS = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [FREE_W-1:0] free_d,
  input  logic [DEP_W-1:0]  rhs_sel,
  output logic [DEP_W-1:0]  dep_q
);
  logic [DEP_W-1:0] dep_d;

  for (genvar i = 0; i < DEP_W; i++) begin : g_dep
    localparam logic [FREE_W-1:0] MASK = DEP_MASKS[i*FREE_W +: FREE_W];
    always_comb begin
      dep_d[i] = masked_parity(KCG_MAX_W'(free_d), KCG_MAX_W'(MASK)) ^ rhs_sel[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dep_q <= '0;
    else if (load_en) dep_q <= dep_d;
  end

  assert_dep_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(dep_q));
endmodule

// File: rtl/kcg_task_ctrl.sv
module kcg_task_ctrl #(
  parameter int unsigned DEP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             task_start,
  input  logic [DEP_W-1:0] task_rhs,
  input  logic             fire,
  input  logic             at_last,
  output logic             active_q,
  output logic             done_q,
  output logic [DEP_W-1:0] rhs_sel
);
  logic             active_d, done_d, state_en;
  logic [DEP_W-1:0] rhs_q;

  always_comb begin
    state_en = task_start | (fire & at_last);
    active_d = task_start;
    done_d   = ~task_start;
    rhs_sel  = task_start ? task_rhs : rhs_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else if (state_en) begin
      active_q <= active_d;
      done_q   <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rhs_q <= '0;
    else if (task_start) rhs_q <= task_rhs;
  end

  assert_rhs_capture_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !task_start |=> $stable(rhs_q));

  assert_exclusive_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(active_q && done_q));

  assert_start_clears_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    task_start |=> (active_q && !done_q));
endmodule

// File: rtl/key_cand_gen.sv
module key_cand_gen #(
  parameter int unsigned             FREE_W    = 4,
  parameter int unsigned             DEP_W     = 3,
  parameter logic [DEP_W*FREE_W-1:0] DEP_MASKS = 12'h9E3,
  localparam int unsigned            KEY_W     = FREE_W + DEP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             task_start,
  input  logic [DEP_W-1:0] task_rhs,
  input  logic             pause,
  input  logic             cand_ready,
  output logic             cand_valid,
  output logic [KEY_W-1:0] cand_key,
  output logic             done
);
  logic              active_q, done_q, fire, at_last, free_en;
  logic [FREE_W-1:0] free_q, free_d;
  logic [DEP_W-1:0]  dep_q, rhs_sel;

  always_comb begin
    cand_valid = active_q & ~pause;
    fire       = cand_valid & cand_ready;
    cand_key   = {dep_q, free_q};
    done       = done_q;
  end

  kcg_task_ctrl #(.DEP_W(DEP_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .task_start(task_start), .task_rhs(task_rhs),
    .fire(fire), .at_last(at_last), .active_q(active_q), .done_q(done_q),
    .rhs_sel(rhs_sel)
  );

  kcg_free_counter #(.FREE_W(FREE_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load_zero(task_start), .step(fire),
    .free_q(free_q), .free_d(free_d), .free_en(free_en), .at_last(at_last)
  );

  kcg_dep_stage #(.FREE_W(FREE_W), .DEP_W(DEP_W), .DEP_MASKS(DEP_MASKS)) u_dep (
    .clk(clk), .rst_n(rst_n), .load_en(free_en), .free_d(free_d),
    .rhs_sel(rhs_sel), .dep_q(dep_q)
  );

  assert_key_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && !cand_ready && !task_start) |=> $stable(cand_key));

  assert_pause_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pause && !task_start) |=> $stable(cand_key));

  assert_done_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cand_valid);

  assert_last_to_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && at_last && !task_start) |=> (done && !cand_valid));
endmodule

// File: tb/key_cand_gen_bench.sv
module key_cand_gen_bench;
  localparam int FW = 4;
  localparam int DW = 3;
  localparam int KW = FW + DW;
  localparam logic [FW-1:0] M0 = 4'b0011;
  localparam logic [FW-1:0] M1 = 4'b1110;
  localparam logic [FW-1:0] M2 = 4'b1001;
  localparam int NV = 4;
  localparam logic [DW-1:0] RHS_TAB [NV] = '{3'b000, 3'b101, 3'b011, 3'b111};

  logic clk = 1'b0;
  logic rst_n, task_start, pause, cand_ready;
  logic [DW-1:0] task_rhs;
  logic cand_valid, done;
  logic [KW-1:0] cand_key;
  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  key_cand_gen #(.FREE_W(FW), .DEP_W(DW), .DEP_MASKS({M2, M1, M0})) u_key_cand_gen (
    .clk(clk), .rst_n(rst_n), .task_start(task_start), .task_rhs(task_rhs),
    .pause(pause), .cand_ready(cand_ready), .cand_valid(cand_valid),
    .cand_key(cand_key), .done(done)
  );

  function automatic logic [KW-1:0] exp_key(input logic [FW-1:0] f, input logic [DW-1:0] b);
    logic [DW-1:0] d;
    d[0] = (^(f & M0)) ^ b[0];
    d[1] = (^(f & M1)) ^ b[1];
    d[2] = (^(f & M2)) ^ b[2];
    return {d, f};
  endfunction

  task automatic chk(input string req, input logic [KW-1:0] act, input logic [KW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic start_task(input logic [DW-1:0] b);
    task_start = 1'b1;
    task_rhs = b;
    tick();
    task_start = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; task_start = 1'b0; pause = 1'b0; cand_ready = 1'b0; task_rhs = '0;
    #5;
    chk("R1 valid in reset", KW'(cand_valid), KW'(0));
    chk("R1 done in reset", KW'(done), KW'(0));
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    tick();
    chk("R1 key after reset", cand_key, '0);
    cand_ready = 1'b1;
    tick(); tick();
    chk("R10 no candidate before task", KW'(cand_valid), KW'(0));
    chk("R10 no done before task", KW'(done), KW'(0));

    // Table walk: each right-hand side, full enumeration (R2, R3, R4, R7)
    for (int v = 0; v < NV; v++) begin
      cand_ready = 1'b1;
      start_task(RHS_TAB[v]);
      for (int k = 0; k < (1 << FW); k++) begin
        chk("R2 valid during task", KW'(cand_valid), KW'(1));
        chk("R3 R4 key sequence", cand_key, exp_key(FW'(k), RHS_TAB[v]));
        tick();
      end
      chk("R7 done after last", KW'(done), KW'(1));
      chk("R7 valid low after last", KW'(cand_valid), KW'(0));
    end
    tick(); tick(); tick();
    chk("R7 done persists", KW'(done), KW'(1));
    chk("R7 valid stays low", KW'(cand_valid), KW'(0));

    // Ready low holds the key (R5)
    cand_ready = 1'b0;
    start_task(3'b101);
    chk("R9 start clears done", KW'(done), KW'(0));
    tick(); tick(); tick();
    chk("R5 key held without ready", cand_key, exp_key(4'd0, 3'b101));
    chk("R5 valid held", KW'(cand_valid), KW'(1));
    cand_ready = 1'b1;
    tick();
    cand_ready = 1'b0;
    chk("R4 single accept", cand_key, exp_key(4'd1, 3'b101));

    // Pause (R6)
    pause = 1'b1;
    cand_ready = 1'b1;
    #1;
    chk("R6 valid drops with pause", KW'(cand_valid), KW'(0));
    @(negedge clk);
    tick(); tick();
    chk("R6 key frozen while paused", cand_key, exp_key(4'd1, 3'b101));
    pause = 1'b0;
    #1;
    chk("R6 valid back after pause", KW'(cand_valid), KW'(1));
    @(negedge clk);
    chk("R6 advance after pause", cand_key, exp_key(4'd2, 3'b101));

    // task_rhs ignored outside start (R8)
    task_rhs = 3'b010;
    tick();
    chk("R8 rhs change ignored", cand_key, exp_key(4'd3, 3'b101));

    // Restart mid-task with concurrent accept (R9)
    task_start = 1'b1;
    task_rhs = 3'b110;
    tick();
    task_start = 1'b0;
    cand_ready = 1'b0;
    chk("R9 restart at zero", cand_key, exp_key(4'd0, 3'b110));
    chk("R9 valid after restart", KW'(cand_valid), KW'(1));

    finish_run();
  end
endmodule